// File: doc/BRIEF.md
# AES Substitute-and-Shift Round Step

This block performs one of the two byte-substitution steps of an AES round on a 128-bit state held in a vector register. The surrounding pipeline presents a 32-bit instruction word together with the current destination operand and the source operand. The block decodes the word. If it names a legal step, the block XORs the two operands and then applies the forward or inverse substitute-and-shift transformation. The result is registered and returned with the destination and source register numbers, so the pipeline can write it back to the destination register.

The forward step substitutes every byte through the AES S-box and rotates the rows of the 4x4 state. The inverse step undoes the row rotation first and then applies the inverse S-box. A forward step followed by an inverse step with a zero source gives back the original XOR of the two operands. Column mixing, key expansion and round sequencing are done elsewhere. Any word that does not decode is flagged as illegal and produces a zero result.

Top module: `aes_subshift_unit`

## Requirements
- R1: A word is legal only when bits 31:24 are 01001110, bits 23:22 (size) are 00, bits 21:17 are 10100 and bits 11:10 are 10. Changing any one of these bits makes the word illegal.
- R2: With the fixed fields correct, opcode bits 16:12 = 00100 select the forward step and 00101 select the inverse step. Every other opcode is illegal. Bits 9:5 (source register) and bits 4:0 (destination register) do not affect the result. They appear registered on `out_rn` and `out_rd`.
- R3: Both steps operate on the bitwise XOR of `dst_op` and `src_op`.
- R4: The forward step replaces every byte through the AES S-box, for example 0x00 becomes 0x63 and 0x01 becomes 0x7c.
- R5: Byte k occupies bits 8k+7:8k, and byte 0 is the least significant byte. For row r = k mod 4 and column c = k div 4, the forward step's output byte at (r, c) is the substituted input byte at (r, (c+r) mod 4). Bytes 0, 4, 8 and 12 do not move.
- R6: The inverse step moves input byte (r, (c-r) mod 4) to output position (r, c) and then applies the inverse S-box, for example 0x00 becomes 0x52 and 0x63 becomes 0x00.
- R7: Results appear one clock after the input is accepted. `out_valid` equals `in_valid` delayed by one cycle. While `in_valid` is low, `out_result` holds its value.
- R8: An illegal word with `in_valid` high raises `out_illegal` for exactly one cycle, alongside `out_valid`, and sets `out_result` to zero.
- R9: An active-low synchronous reset clears `out_valid`, `out_illegal`, `out_result`, `out_rn` and `out_rd`.
- R10: A forward step on any state, followed by an inverse step whose destination operand is that result and whose source operand is zero, returns the original state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| dst_op | input | 128 | Destination register operand |
| src_op | input | 128 | Source register operand |
| out_valid | output | 1 | Registered result present |
| out_illegal | output | 1 | Registered instruction failed decode |
| out_result | output | 128 | Registered transformed state |
| out_rn | output | 5 | Registered source register number |
| out_rd | output | 5 | Registered destination register number |

## Verification
Every result, illegal flag and register tag is due on the first rising edge after the cycle in which `in_valid` is high. The bench drives each request on a falling edge and removes it on the next falling edge, then samples all outputs at that falling edge, which is half a period after the capturing edge. On idle cycles the bench expects `out_valid` low and the result unchanged, because no register lies on the path except the output stage. The S-box tables are built in the bench by brute-force search for field inverses, and both directions are swept over all 256 byte values.

// File: rtl/aes_step_pkg.sv
// Package: shared decode type, field constants and GF(2^8) arithmetic
// for the substitute-and-shift round step. Assumes the AES field
// polynomial x^8+x^4+x^3+x+1.
package aes_step_pkg;

    localparam int BYTE_W   = 8;
    localparam int N_BYTES  = 16;
    localparam int STATE_W  = BYTE_W * N_BYTES;
    localparam int REG_W    = 5;

    localparam logic [7:0] TOP_FIELD  = 8'b0100_1110;
    localparam logic [4:0] MID_FIELD  = 5'b10100;
    localparam logic [1:0] LOW_FIELD  = 2'b10;
    localparam logic [1:0] SIZE_FIELD = 2'b00;
    localparam logic [4:0] OP_FWD     = 5'b00100;
    localparam logic [4:0] OP_INV     = 5'b00101;

    typedef struct packed {
        logic legal;
        logic inverse;
    } step_dec_t;

    // Multiply by x modulo the field polynomial.
    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // Field multiply by shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Field inverse as a^254 (maps zero to zero).
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p;
        logic [7:0] r;
        p = a;
        r = 8'h01;
        for (int k = 1; k < 8; k++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    // Forward S-box: inverse, then affine map.
    function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    // Inverse S-box: inverse affine map, then field inverse.
    function automatic logic [7:0] sbox_inv(input logic [7:0] a);
        return gf_inv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
    endfunction

endpackage

// File: rtl/aes_step_decode.sv
// Decoder: checks the fixed fields and the opcode of the upper
// instruction bits (31:10). Register fields are not examined here.
module aes_step_decode
    import aes_step_pkg::*;
(
    input  logic [31:10] instr_hi,
    output step_dec_t    dec
);
    logic fixed_ok;
    logic [4:0] opcode;

    // Match the constant fields and the size field.
    always_comb begin
        opcode   = instr_hi[16:12];
        fixed_ok = (instr_hi[31:24] == TOP_FIELD) &&
                   (instr_hi[23:22] == SIZE_FIELD) &&
                   (instr_hi[21:17] == MID_FIELD) &&
                   (instr_hi[11:10] == LOW_FIELD);
        dec.legal   = fixed_ok && ((opcode == OP_FWD) || (opcode == OP_INV));
        dec.inverse = (opcode == OP_INV);
    end
endmodule

// File: rtl/aes_byte_sub.sv
// Byte substitution across a whole state: one S-box lane per byte,
// forward or inverse selected by parameter. Purely combinational.
module aes_byte_sub
    import aes_step_pkg::*;
#(
    parameter bit INVERSE = 1'b0,
    parameter int NB      = N_BYTES
) (
    input  logic [NB*8-1:0] din,
    output logic [NB*8-1:0] dout
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        if (INVERSE) begin : g_inv
            // Inverse substitution for lane i.
            assign dout[8*i +: 8] = sbox_inv(din[8*i +: 8]);
        end else begin : g_fwd
            // Forward substitution for lane i.
            assign dout[8*i +: 8] = sbox_fwd(din[8*i +: 8]);
        end
    end
endmodule

// File: rtl/aes_row_rotate.sv
// Row rotation of a column-major 4x4 byte state (byte k sits in row
// k%4, column k/4). Row r rotates by r columns; the direction is set
// by parameter. Pure wiring.
module aes_row_rotate
    import aes_step_pkg::*;
#(
    parameter bit INVERSE = 1'b0,
    parameter int ROWS    = 4
) (
    input  logic [ROWS*ROWS*8-1:0] din,
    output logic [ROWS*ROWS*8-1:0] dout
);
    localparam int NB = ROWS * ROWS;

    for (genvar k = 0; k < NB; k++) begin : g_byte
        localparam int R     = k % ROWS;
        localparam int C     = k / ROWS;
        localparam int SRC_C = INVERSE ? (C - R + ROWS) % ROWS : (C + R) % ROWS;
        localparam int SRC_K = R + ROWS * SRC_C;
        // Route one byte to its rotated position.
        assign dout[8*k +: 8] = din[8*SRC_K +: 8];
    end
endmodule

// File: rtl/aes_subshift_unit.sv
// Top: decodes a step instruction, XORs the two operands, runs the
// forward (substitute then rotate) or inverse (unrotate then inverse
// substitute) path and registers the result with one cycle latency.
// Assumes operands are stable in the cycle in_valid is high.
module aes_subshift_unit
    import aes_step_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [31:0]         instr,
    input  logic [STATE_W-1:0]  dst_op,
    input  logic [STATE_W-1:0]  src_op,
    output logic                out_valid,
    output logic                out_illegal,
    output logic [STATE_W-1:0]  out_result,
    output logic [REG_W-1:0]    out_rn,
    output logic [REG_W-1:0]    out_rd
);
    step_dec_t          dec;
    logic [STATE_W-1:0] mixed;
    logic [STATE_W-1:0] fwd_sub, fwd_out;
    logic [STATE_W-1:0] inv_rot, inv_out;
    logic [STATE_W-1:0] next_result;

    aes_step_decode u_dec (
        .instr_hi (instr[31:10]),
        .dec      (dec)
    );

    // Combine the round key operand with the state.
    assign mixed = dst_op ^ src_op;

    aes_byte_sub   #(.INVERSE(1'b0)) u_fwd_sub (.din(mixed),   .dout(fwd_sub));
    aes_row_rotate #(.INVERSE(1'b0)) u_fwd_rot (.din(fwd_sub), .dout(fwd_out));
    aes_row_rotate #(.INVERSE(1'b1)) u_inv_rot (.din(mixed),   .dout(inv_rot));
    aes_byte_sub   #(.INVERSE(1'b1)) u_inv_sub (.din(inv_rot), .dout(inv_out));

    // Select the path for the decoded step; illegal words give zero.
    always_comb begin
        if (!dec.legal)      next_result = '0;
        else if (dec.inverse) next_result = inv_out;
        else                 next_result = fwd_out;
    end

    // Output stage: valid/illegal every cycle, data only on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
            out_rn      <= '0;
            out_rd      <= '0;
        end else begin
            out_valid   <= in_valid;
            out_illegal <= in_valid && !dec.legal;
            if (in_valid) begin
                out_result <= next_result;
                out_rn     <= instr[9:5];
                out_rd     <= instr[4:0];
            end
        end
    end
endmodule

// File: rtl/aes_subshift_checker.sv
// Checker: temporal properties on the ports of aes_subshift_unit,
// attached with bind. Assumes the synchronous active-low reset.
module aes_subshift_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [31:0]  instr,
    input logic         out_valid,
    input logic         out_illegal,
    input logic [127:0] out_result
);
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
    p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_result == 128'd0) && out_valid);
    p_illegal_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_illegal);
    p_bad_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[23:22] != 2'b00) |=> out_illegal);
    p_bad_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[16:13] != 4'b0010) |=> out_illegal);
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !out_illegal);
endmodule

bind aes_subshift_unit aes_subshift_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .instr       (instr),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_result  (out_result)
);

// File: tb/aes_subshift_unit_bench.sv
// Bench: builds S-box tables by brute force, sweeps all byte values in
// both directions, sweeps illegal encodings and runs random round trips.
module aes_subshift_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] dst_op = '0;
    logic [127:0] src_op = '0;
    logic         out_valid;
    logic         out_illegal;
    logic [127:0] out_result;
    logic [4:0]   out_rn;
    logic [4:0]   out_rd;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] sb  [256];
    logic [7:0] isb [256];

    always #2.5 clk = ~clk;

    aes_subshift_unit u_aes_subshift_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .dst_op(dst_op), .src_op(src_op), .out_valid(out_valid),
        .out_illegal(out_illegal), .out_result(out_result),
        .out_rn(out_rn), .out_rd(out_rd)
    );

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] op, input logic [4:0] rn,
                                       input logic [4:0] rd);
        return {8'h4E, 2'b00, 5'b10100, op, 2'b10, rn, rd};
    endfunction

    function automatic logic [127:0] rot(input logic [127:0] s, input bit inv);
        logic [127:0] o;
        for (int k = 0; k < 16; k++) begin
            int r = k % 4;
            int c = k / 4;
            int sc = inv ? (c - r + 4) % 4 : (c + r) % 4;
            o[8*k +: 8] = s[8*(r + 4*sc) +: 8];
        end
        return o;
    endfunction

    function automatic logic [127:0] subs(input logic [127:0] s, input bit inv);
        logic [127:0] o;
        for (int k = 0; k < 16; k++)
            o[8*k +: 8] = inv ? isb[s[8*k +: 8]] : sb[s[8*k +: 8]];
        return o;
    endfunction

    function automatic logic [127:0] model(input bit inv, input logic [127:0] d,
                                           input logic [127:0] s);
        return inv ? subs(rot(d ^ s, 1'b1), 1'b1) : rot(subs(d ^ s, 1'b0), 1'b0);
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // One request; outputs are sampled on the falling edge after capture.
    task automatic issue(input logic [31:0] w, input logic [127:0] d, input logic [127:0] s);
        @(negedge clk);
        instr = w; dst_op = d; src_op = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        logic [127:0] st, k, y, held;
        logic [31:0] good;
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv, v;
            inv = 8'h00;
            for (int b = 1; b < 256; b++) if (fmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            for (int i = 0; i < 8; i++)
                v[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
                       ^ ((8'h63 >> i) & 1'b1);
            sb[a] = v;
        end
        for (int a = 0; a < 256; a++) isb[sb[a]] = 8'(a);

        repeat (3) @(negedge clk);
        check("R9 valid", {127'd0, out_valid}, 128'd0);
        check("R9 illegal", {127'd0, out_illegal}, 128'd0);
        check("R9 result", out_result, 128'd0);
        check("R9 tags", {118'd0, out_rn, out_rd}, 128'd0);
        rst_n = 1'b1;

        // R4 R6: every byte value through both S-boxes (uniform states).
        check("R4 table 00", {120'd0, sb[0]}, {120'd0, 8'h63});
        check("R4 table 01", {120'd0, sb[1]}, {120'd0, 8'h7c});
        check("R6 table 00", {120'd0, isb[0]}, {120'd0, 8'h52});
        check("R6 table 63", {120'd0, isb[8'h63]}, {120'd0, 8'h00});
        for (int v = 0; v < 256; v++) begin
            issue(mk(5'b00100, 5'd1, 5'd2), {16{8'(v)}}, '0);
            check("R4 fwd sweep", out_result, {16{sb[v]}});
            issue(mk(5'b00101, 5'd3, 5'd4), {16{8'(v)}}, '0);
            check("R6 inv sweep", out_result, {16{isb[v]}});
        end
        issue(mk(5'b00100, 5'd0, 5'd0), 128'd0, 128'd0);
        check("R4 zero state", out_result, {16{8'h63}});

        // R5: distinct bytes expose the row permutation and byte order.
        st = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
        issue(mk(5'b00100, 5'd7, 5'd9), st, '0);
        check("R5 fwd perm", out_result, rot(subs(st, 1'b0), 1'b0));
        check("R5 byte1 from byte5", {120'd0, out_result[15:8]}, {120'd0, sb[5]});
        issue(mk(5'b00101, 5'd7, 5'd9), st, '0);
        check("R6 inv perm", out_result, subs(rot(st, 1'b1), 1'b1));

        // R3 R2: random operands and register fields.
        for (int t = 0; t < 40; t++) begin
            logic [4:0] rn, rd;
            st = {$urandom, $urandom, $urandom, $urandom};
            k  = {$urandom, $urandom, $urandom, $urandom};
            rn = 5'($urandom); rd = 5'($urandom);
            issue(mk(5'b00100, rn, rd), st, k);
            check("R3 fwd xor", out_result, model(1'b0, st, k));
            check("R2 tags", {118'd0, out_rn, out_rd}, {118'd0, rn, rd});
            check("R7 valid", {127'd0, out_valid}, 128'd1);
            issue(mk(5'b00101, rd, rn), st, k);
            check("R3 inv xor", out_result, model(1'b1, st, k));
        end

        // R7: idle cycle drops valid and holds the result.
        held = out_result;
        @(negedge clk);
        check("R7 idle valid", {127'd0, out_valid}, 128'd0);
        check("R7 idle hold", out_result, held);

        // R1: flip each fixed-field bit of a legal word.
        good = mk(5'b00100, 5'd5, 5'd6);
        for (int b = 10; b < 32; b++) begin
            if (b >= 12 && b <= 16) continue;
            issue(good ^ (32'd1 << b), {4{32'hdeadbeef}}, 128'd1);
            check("R1 illegal flag", {127'd0, out_illegal}, 128'd1);
            check("R8 zero result", out_result, 128'd0);
            check("R8 valid with illegal", {127'd0, out_valid}, 128'd1);
            @(negedge clk);
            check("R8 single cycle", {127'd0, out_illegal}, 128'd0);
        end
        // R2: every other opcode is illegal.
        for (int op = 0; op < 32; op++) begin
            if (op == 4 || op == 5) continue;
            issue(mk(5'(op), 5'd1, 5'd1), {4{32'h12345678}}, '0);
            check("R2 opcode illegal", {127'd0, out_illegal}, 128'd1);
            check("R8 opcode zero", out_result, 128'd0);
        end
        issue(good, 128'd0, 128'd0);
        check("R2 legal clears flag", {127'd0, out_illegal}, 128'd0);

        // R10: forward then inverse with zero source returns the state.
        for (int t = 0; t < 100; t++) begin
            st = {$urandom, $urandom, $urandom, $urandom};
            k  = {$urandom, $urandom, $urandom, $urandom};
            issue(mk(5'b00100, 5'd2, 5'd3), st, k);
            y = out_result;
            issue(mk(5'b00101, 5'd2, 5'd3), y, 128'd0);
            check("R10 round trip", out_result, st ^ k);
        end

        // R9: reset mid-run clears outputs.
        issue(good, {4{32'hffffffff}}, '0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 result after reset", out_result, 128'd0);
        check("R9 valid after reset", {127'd0, out_valid}, 128'd0);
        report();
    end
endmodule